// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block is the coherence engine for one write-back, direct-mapped cache in a small shared-bus multiprocessor. Every line it holds is in one of four states. Modified means the copy is private and newer than memory. Exclusive means the copy is private and matches memory. Shared means other caches may also hold the line, and the copy matches memory. Invalid means the line holds nothing. The CPU side presents one request at a time. Hits that need no permission complete at once. Anything else makes the controller request the bus, wait for the grant, and issue one coherence command.

On a read miss, the controller samples a wired-OR shared line in the cycle its command is on the bus. It installs the line Exclusive when no other cache holds a copy, and Shared when one does. A write to an Exclusive line becomes Modified without any bus traffic. A write to a Shared line sends an invalidate-only upgrade, which does not wait for data.

The controller also watches the commands of other masters on the snoop input. It asserts its share of the shared line when it holds the line. It supplies dirty data from the cache, and it demotes or invalidates its own copy as required. Memory, the arbiter and the other caches live outside the block.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_done` and `bus_req` are low, and `bus_cmd_o` is idle (0).
- R2: A CPU read that hits a valid line (tag equal to the address bits above the low log2(LINES) index bits) asserts `cpu_done` in the same cycle, returns the stored data, and places no command on the bus.
- R3: A CPU read miss raises `bus_req`. After the grant it drives read-miss (code 1) with the address. It samples `shared_i` in that cycle, takes its data from a later reply (code 5) with a matching address on the snoop input, and installs the line Exclusive if `shared_i` was low or Shared if it was high.
- R4: A CPU write to an Exclusive line completes with no bus command and leaves the line Modified.
- R5: A CPU write to a Shared line issues exactly one upgrade (code 3) and waits for no data. `cpu_done` follows in the next cycle, and the line becomes Modified.
- R6: A CPU write miss issues write-miss (code 2), fills the line from the reply, merges the write data, and leaves the line Modified.
- R7: A miss whose index holds a Modified line with another tag first drives write-back (code 4) with the victim's address and data, then the miss command.
- R8: `shared_o` is high in exactly the cycles where the snoop input carries read-miss (code 1) for an address held in Modified, Exclusive or Shared.
- R9: A snooped read-miss to a Modified line drives reply (code 5) with the line's address and data in the next cycle, and the line becomes Shared. A snooped read-miss to an Exclusive line makes it Shared.
- R10: A snooped write-miss (code 2) to a Modified line drives a reply with its data in the next cycle and invalidates it. To an Exclusive or Shared line, it invalidates without any reply.
- R11: A snooped upgrade (code 3) to an Exclusive or Shared line invalidates it without any data transfer.
- R12: The controller drives read-miss, write-miss, upgrade or write-back only while both `bus_req` and `bus_gnt` are high. `cpu_done` is only ever high while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes in this cycle |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_o | output | 3 | Command driven: 0 idle, 1 read-miss, 2 write-miss, 3 upgrade, 4 write-back, 5 reply |
| bus_addr_o | output | ADDR_W | Address driven with the command |
| bus_data_o | output | DATA_W | Data for write-back and reply |
| shared_o | output | 1 | This cache's term of the wired-OR shared line |
| shared_i | input | 1 | Resolved wired-OR shared line |
| snp_cmd | input | 3 | Command of another master seen on the bus |
| snp_addr | input | ADDR_W | Address seen with `snp_cmd` |
| snp_data | input | DATA_W | Data seen with a reply |

## Verification
Several rules are checked on every cycle. Own commands appear only under grant. The shared term follows only a snooped read-miss. A dirty snoop hit is followed one cycle later by a reply. An upgrade is followed at once by completion. A silent Exclusive write never raises the bus request. The state reached after each transition is not visible at the ports, so only the bench can show it. The bench sweeps every starting state against every CPU and snoop event, then probes the resulting state through later bus traffic. Evictions of dirty victims and the data values carried through memory are also shown only by its scenarios.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;

  typedef enum logic [2:0] {
    BC_IDLE    = 3'd0,
    BC_RDMISS  = 3'd1,
    BC_WRMISS  = 3'd2,
    BC_UPGRADE = 3'd3,
    BC_WRBACK  = 3'd4,
    BC_REPLY   = 3'd5
  } bus_cmd_t;

  // state installed when a miss is filled
  function automatic line_st_t fill_state(input logic is_write, input logic seen_shared);
    if (is_write) return ST_M;
    return seen_shared ? ST_S : ST_E;
  endfunction

  // state after another master's command hits this line
  function automatic line_st_t snoop_next(input line_st_t cur, input logic [2:0] cmd);
    case (cmd)
      BC_RDMISS:             return (cur == ST_I) ? ST_I : ST_S;
      BC_WRMISS, BC_UPGRADE: return ST_I;
      default:               return cur;
    endcase
  endfunction

  function automatic logic snoop_supplies(input line_st_t cur, input logic [2:0] cmd);
    return (cur == ST_M) && (cmd == BC_RDMISS || cmd == BC_WRMISS);
  endfunction

  function automatic logic snoop_shares(input line_st_t cur, input logic [2:0] cmd);
    return (cmd == BC_RDMISS) && (cur != ST_I);
  endfunction
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store import mesi_pkg::*; #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  c_idx,
  output line_st_t          c_st,
  output logic [TAG_W-1:0]  c_tag,
  output logic [DATA_W-1:0] c_data,
  input  logic              c_we,
  input  line_st_t          c_wst,
  input  logic [TAG_W-1:0]  c_wtag,
  input  logic [DATA_W-1:0] c_wdata,
  input  logic [IDX_W-1:0]  s_idx,
  output line_st_t          s_st,
  output logic [TAG_W-1:0]  s_tag,
  output logic [DATA_W-1:0] s_data,
  input  logic              s_we,
  input  line_st_t          s_wst
);
  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign c_st   = st_q[c_idx];
  assign c_tag  = tag_q[c_idx];
  assign c_data = data_q[c_idx];
  assign s_st   = st_q[s_idx];
  assign s_tag  = tag_q[s_idx];
  assign s_data = data_q[s_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (c_we && c_idx == IDX_W'(g)) begin
        st_q[g]   <= c_wst;
        tag_q[g]  <= c_wtag;
        data_q[g] <= c_wdata;
      end else if (s_we && s_idx == IDX_W'(g)) begin
        st_q[g]   <= s_wst;
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_o,
  output logic              upd_we,
  output line_st_t          upd_st,
  output logic              supply_ev,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  logic line_hit;
  assign line_hit  = enable && line_st != ST_I && line_tag == snp_addr[ADDR_W-1:IDX_W];
  assign shared_o  = line_hit && snoop_shares(line_st, snp_cmd);
  assign upd_st    = snoop_next(line_st, snp_cmd);
  assign upd_we    = line_hit && upd_st != line_st;
  assign supply_ev = line_hit && snoop_supplies(line_st, snp_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= supply_ev;
      if (supply_ev) begin
        rsp_addr <= snp_addr;
        rsp_data <= line_data;
      end
    end
  end
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              shared_o,
  input  logic              shared_i,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {F_IDLE, F_ARB, F_WB, F_CMD, F_DATA} fsm_t;

  fsm_t              fsm_q, fsm_d;
  bus_cmd_t          cmd_q, cmd_d;
  logic              shared_q;
  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  c_tag_req, c_tag;
  line_st_t          c_st, s_st, wr_st, upd_st;
  logic [DATA_W-1:0] c_data, s_data, wr_data, rsp_data;
  logic [TAG_W-1:0]  s_tag;
  logic [ADDR_W-1:0] rsp_addr;
  logic              c_hit, snp_en, wr_en, upd_we, rsp_valid;
  // named events for the checker
  logic              ev_supply, ev_upgrade, ev_silent_write, ev_fill;

  assign c_idx     = cpu_addr[IDX_W-1:0];
  assign c_tag_req = cpu_addr[ADDR_W-1:IDX_W];
  assign c_hit     = c_st != ST_I && c_tag == c_tag_req;
  assign snp_en    = (fsm_q == F_IDLE || fsm_q == F_ARB) &&
                     (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS || snp_cmd == BC_UPGRADE);

  assign cpu_done  = fsm_q == F_IDLE && cpu_req && !snp_en && c_hit &&
                     (!cpu_we || c_st == ST_E || c_st == ST_M);
  assign cpu_rdata = c_data;
  assign bus_req   = fsm_q != F_IDLE;

  assign ev_silent_write = cpu_done && cpu_we && c_st == ST_E;
  assign ev_upgrade      = fsm_q == F_CMD && cmd_q == BC_UPGRADE;
  assign ev_fill         = fsm_q == F_DATA && snp_cmd == BC_REPLY && snp_addr == cpu_addr;

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .c_idx, .c_st, .c_tag, .c_data,
    .c_we(wr_en), .c_wst(wr_st), .c_wtag(c_tag_req), .c_wdata(wr_data),
    .s_idx(snp_addr[IDX_W-1:0]), .s_st, .s_tag, .s_data,
    .s_we(upd_we), .s_wst(upd_st)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_snoop (
    .clk, .rst_n, .enable(snp_en), .snp_cmd, .snp_addr,
    .line_st(s_st), .line_tag(s_tag), .line_data(s_data),
    .shared_o, .upd_we, .upd_st, .supply_ev(ev_supply),
    .rsp_valid, .rsp_addr, .rsp_data
  );

  always_comb begin
    fsm_d   = fsm_q;
    cmd_d   = cmd_q;
    wr_en   = 1'b0;
    wr_st   = ST_M;
    wr_data = c_data;
    case (fsm_q)
      F_IDLE: begin
        if (cpu_done && cpu_we) begin
          wr_en   = 1'b1;
          wr_data = cpu_wdata;
        end else if (cpu_req && !snp_en && !cpu_done) begin
          fsm_d = F_ARB;
        end
      end
      F_ARB: begin
        if (bus_gnt && !snp_en) begin
          if (c_hit && (!cpu_we || c_st != ST_S)) begin
            fsm_d = F_IDLE;
          end else if (c_hit) begin
            cmd_d = BC_UPGRADE;
            fsm_d = F_CMD;
          end else begin
            cmd_d = cpu_we ? BC_WRMISS : BC_RDMISS;
            fsm_d = (c_st == ST_M) ? F_WB : F_CMD;
          end
        end
      end
      F_WB: fsm_d = F_CMD;
      F_CMD: begin
        if (cmd_q == BC_UPGRADE) begin
          wr_en = 1'b1;
          fsm_d = F_IDLE;
        end else begin
          fsm_d = F_DATA;
        end
      end
      F_DATA: begin
        if (ev_fill) begin
          wr_en   = 1'b1;
          wr_st   = fill_state(cmd_q == BC_WRMISS, shared_q);
          wr_data = snp_data;
          fsm_d   = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q    <= F_IDLE;
      cmd_q    <= BC_IDLE;
      shared_q <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      cmd_q <= cmd_d;
      if (fsm_q == F_CMD) shared_q <= shared_i;
    end
  end

  always_comb begin
    case (fsm_q)
      F_WB: begin
        bus_cmd_o  = BC_WRBACK;
        bus_addr_o = {c_tag, c_idx};
        bus_data_o = c_data;
      end
      F_CMD: begin
        bus_cmd_o  = cmd_q;
        bus_addr_o = cpu_addr;
        bus_data_o = '0;
      end
      default: begin
        bus_cmd_o  = rsp_valid ? BC_REPLY : BC_IDLE;
        bus_addr_o = rsp_valid ? rsp_addr : '0;
        bus_data_o = rsp_valid ? rsp_data : '0;
      end
    endcase
  end
endmodule

// File: rtl/mesi_cache_ctrl_chk.sv
module mesi_cache_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [2:0] bus_cmd_o,
  input logic       shared_o,
  input logic [2:0] snp_cmd,
  input logic       ev_supply,
  input logic       ev_upgrade,
  input logic       ev_silent_write
);
  assert_own_cmd_granted_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> (bus_req && bus_gnt));

  assert_done_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_req);

  assert_shared_only_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shared_o |-> snp_cmd == 3'd1);

  assert_dirty_snoop_replies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_supply |=> bus_cmd_o == 3'd5);

  assert_upgrade_no_data_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upgrade |=> (cpu_done || !cpu_req || snp_cmd inside {3'd1, 3'd2, 3'd3}));

  assert_silent_exclusive_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_silent_write |-> !bus_req);
endmodule

bind mesi_cache_ctrl mesi_cache_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
  .shared_o(shared_o), .snp_cmd(snp_cmd), .ev_supply(ev_supply),
  .ev_upgrade(ev_upgrade), .ev_silent_write(ev_silent_write)
);

// File: tb/mesi_cache_ctrl_tb.sv
module mesi_cache_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NL = 2;
  localparam logic [2:0] C_IDLE = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_UPG = 3'd3,
                         C_WB = 3'd4, C_REPLY = 3'd5;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, shared_i = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, snp_data = '0;
  logic [2:0] snp_cmd = C_IDLE;
  logic [DW-1:0] cpu_rdata, bus_data_o;
  logic cpu_done, bus_req, shared_o;
  logic [2:0] bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] mem [16];
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_done,
    .bus_req, .bus_gnt, .bus_cmd_o, .bus_addr_o, .bus_data_o, .shared_o, .shared_i,
    .snp_cmd, .snp_addr, .snp_data);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic shr, output int ncmd, output logic [2:0] first,
                        output logic [DW-1:0] rd);
    logic pend = 0, fin = 0;
    int guard = 0;
    ncmd = 0; first = C_IDLE; rd = '0;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!fin && guard < 60) begin
      #1;
      if (cpu_done) begin
        rd = cpu_rdata; fin = 1;
      end else begin
        if (bus_cmd_o != C_IDLE) begin
          ncmd++;
          if (ncmd == 1) first = bus_cmd_o;
          if (bus_cmd_o == C_WB) mem[bus_addr_o] = bus_data_o;
        end
        shared_i = (bus_cmd_o == C_RD) ? shr : 1'b0;
        if (pend) begin snp_cmd = C_REPLY; snp_addr = a; snp_data = mem[a]; end
        else snp_cmd = C_IDLE;
        pend = (bus_cmd_o == C_RD || bus_cmd_o == C_WR);
        bus_gnt = bus_req;
        @(negedge clk);
        guard++;
      end
    end
    chk(fin, "R12 cpu request completes", int'(fin), 1);
    @(posedge clk); #1;
    cpu_req = 0; bus_gnt = 0; snp_cmd = C_IDLE; shared_i = 0;
    @(negedge clk);
  endtask

  task automatic snoop(input logic [2:0] c, input logic [AW-1:0] a,
                       output logic sh, output logic rep, output logic [DW-1:0] rdat);
    snp_cmd = c; snp_addr = a; #1;
    sh = shared_o;
    @(negedge clk);
    snp_cmd = C_IDLE; #1;
    rep = (bus_cmd_o == C_REPLY) && (bus_addr_o == a);
    rdat = bus_data_o;
    if (rep) mem[a] = rdat;
    @(negedge clk);
  endtask

  task automatic flush_all();
    logic sh, rep;
    logic [DW-1:0] d;
    for (int i = 0; i < 16; i++) snoop(C_WR, AW'(i), sh, rep, d);
  endtask

  // brings the line holding address a into state s; returns its data
  task automatic setup(input int s, input logic [AW-1:0] a, output logic [DW-1:0] val);
    int n;
    logic [2:0] f;
    logic [DW-1:0] rd;
    flush_all();
    val = mem[a];
    if (s == SE || s == SM) cpu_op(0, a, '0, 1'b0, n, f, rd);
    if (s == SS) cpu_op(0, a, '0, 1'b1, n, f, rd);
    if (s == SM) begin
      val = 8'hA0 ^ DW'(a);
      cpu_op(1, a, val, 1'b0, n, f, rd);
    end
  endtask

  // observes the line state through bus traffic
  task automatic probe(input int s, input logic [AW-1:0] a, input logic [DW-1:0] val);
    int n;
    logic [2:0] f;
    logic [DW-1:0] rd, d;
    logic sh, rep;
    case (s)
      SI: begin
        snoop(C_RD, a, sh, rep, d);
        chk(!sh && !rep, "R10/R11 probe line invalid", int'(sh) + int'(rep), 0);
      end
      SE: begin
        cpu_op(1, a, 8'hE7, 1'b0, n, f, rd);
        chk(n == 0, "R4 probe line exclusive: silent write", n, 0);
      end
      SS: begin
        cpu_op(1, a, 8'h3C, 1'b0, n, f, rd);
        chk(n == 1 && f == C_UPG, "R5 probe line shared: one upgrade", int'(f), C_UPG);
      end
      default: begin
        snoop(C_RD, a, sh, rep, d);
        chk(sh && rep && d == val, "R9 probe line modified: reply data", int'(d), int'(val));
      end
    endcase
  endtask

  initial begin
    int n, ns;
    logic [2:0] f;
    logic [DW-1:0] rd, val, d, wd;
    logic [AW-1:0] a;
    logic sh, rep;
    for (int i = 0; i < 16; i++) mem[i] = DW'(8'h30 + i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_done && !bus_req && bus_cmd_o == C_IDLE, "R1 outputs idle after reset",
        int'(bus_req) + int'(cpu_done) + int'(bus_cmd_o), 0);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      snoop(C_RD, AW'(i), sh, rep, d);
      chk(!sh && !rep, "R1 line invalid after reset", int'(sh), 0);
    end

    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 5; e++) begin
        if (s == SM && e == 4) continue;
        a = AW'((s * 5 + e * 3) % 16);
        setup(s, a, val);
        ns = s;
        case (e)
          0: begin
            cpu_op(0, a, '0, 1'b0, n, f, rd);
            if (s == SI) begin
              chk(n == 1 && f == C_RD, "R3 read miss issues one read-miss", int'(f), C_RD);
              ns = SE;
            end else chk(n == 0, "R2 read hit uses no bus", n, 0);
            chk(rd == val, "R2/R3 read data", int'(rd), int'(val));
          end
          1: begin
            wd = 8'h5C + DW'(a);
            cpu_op(1, a, wd, 1'b0, n, f, rd);
            case (s)
              SI: chk(n == 1 && f == C_WR, "R6 write miss issues write-miss", int'(f), C_WR);
              SS: chk(n == 1 && f == C_UPG, "R5 shared write issues one upgrade", int'(f), C_UPG);
              default: chk(n == 0, "R4 write to private line is silent", n, 0);
            endcase
            ns = SM; val = wd;
          end
          2: begin
            snoop(C_RD, a, sh, rep, d);
            chk(sh == (s != SI), "R8 shared term on snooped read", int'(sh), int'(s != SI));
            chk(rep == (s == SM), "R9 reply only from modified", int'(rep), int'(s == SM));
            if (s == SM) chk(d == val, "R9 reply data", int'(d), int'(val));
            ns = (s == SI) ? SI : SS;
          end
          3: begin
            snoop(C_WR, a, sh, rep, d);
            chk(!sh, "R8 no shared term on snooped write-miss", int'(sh), 0);
            chk(rep == (s == SM), "R10 write-miss reply only from modified", int'(rep), int'(s == SM));
            if (s == SM) chk(d == val, "R10 write-back data", int'(d), int'(val));
            ns = SI;
          end
          default: begin
            snoop(C_UPG, a, sh, rep, d);
            chk(!sh && !rep, "R11 upgrade snoop moves no data", int'(sh) + int'(rep), 0);
            ns = SI;
          end
        endcase
        probe(ns, a, val);
      end
    end

    // conflict eviction of a dirty victim: addresses 1 and 3 share index 1
    flush_all();
    cpu_op(1, 4'd1, 8'hC9, 1'b0, n, f, rd);
    chk(n == 1 && f == C_WR, "R6 write miss before eviction", int'(f), C_WR);
    cpu_op(0, 4'd3, '0, 1'b1, n, f, rd);
    chk(n == 2 && f == C_WB, "R7 write-back precedes miss", int'(f), C_WB);
    chk(mem[1] == 8'hC9, "R7 victim data written back", int'(mem[1]), 8'hC9);
    chk(rd == mem[3], "R3 data after eviction", int'(rd), int'(mem[3]));
    probe(SS, 4'd3, mem[3]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL R12 watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule